// File: doc/BRIEF.md
# Cycle-Qualified Gated Event Scaler

The block counts trigger events for four channels. Each channel has a 32-bit counter on the tick clock. The counter advances by one on a tick where the channel's fired input is high and the qualifying strobe is active. The qualifying strobe is pulsed once per long trigger cycle, so a channel gains at most one count per cycle, however long its fired input stays high.

Each counter can be cleared in two ways. The first is a shared timing-signal reset, which acts only on channels whose bit is set in an enable register. The second is a per-channel force bit, which clears its counter on every tick for as long as the bit is set.

Software never reads a live counter. A monitor-capture strobe copies all counters into snapshot registers on the same tick. A simple register port reads each snapshot back as a low 16-bit word and a high 16-bit word, and the snapshot does not change between the two reads.

Top module: `evs_top`

## Requirements
- R1: After reset, every register address reads 0: the reset-enable register, the force register and all eight snapshot words.
- R2: On a tick edge where fired_i[c] and qual_stb_i are both 1 and channel c is not being cleared, counter c rises by exactly one. On any other tick edge without a clear, counter c keeps its value.
- R3: On a tick edge with ts_reset_i high, counter c is cleared only if bit c of the reset-enable register (address 0) is 1. A channel whose enable bit is 0 keeps counting as normal.
- R4: While bit c of the force register (address 1) is 1, counter c is cleared on every tick edge, whatever the value of the reset-enable register.
- R5: A clear from either source wins over an increment on the same tick edge, so the counter ends that edge at 0.
- R6: On a tick edge with mon_cap_i high, every snapshot takes the value its counter held just before that edge. Every channel is captured on the same edge. Without mon_cap_i, a snapshot keeps its value.
- R7: Snapshot c is read as its low word (bits 15:0) at address 8+2c and its high word (bits 31:16) at address 9+2c, for channels 0 to 3 in order.
- R8: Addresses 0 and 1 can be written while reg_wr_i is 1. A read returns the register in bits 3:0 and zeros above them. Any address not mapped above reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| fired_i | input | 4 | Per-channel fired signal |
| qual_stb_i | input | 1 | Once-per-cycle qualifying strobe |
| ts_reset_i | input | 1 | Timing-signal counter reset |
| mon_cap_i | input | 1 | Monitor capture strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |

## Verification
Directed patterns separate the two halves of the increment condition:
- A fired input held high with no strobe must not count.
- A strobe on a channel that has not fired must not count.
- Alternating channel masks show that each channel counts only its own events.

Further directed cases put a timing reset, with one channel enabled, on the same tick as an increment. This tells the enable gating apart from the priority of a clear over an increment. Holding a force bit with its enable cleared shows that the forced clear does not depend on the enable.

A random phase then mixes fired masks, strobes, timing resets, captures and register writes. It reads a random address on every tick and compares the result with a bench model. This checks that snapshots stay frozen between captures and that the word map is correct.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int EVS_ADDR_TSEN  = 0;
  localparam int EVS_ADDR_FORCE = 1;
  localparam int EVS_ADDR_MON   = 8;

  // address of one snapshot word: low word first, then high word, channel by channel
  function automatic int evs_mon_addr(int ch, int hi);
    return EVS_ADDR_MON + 2 * ch + hi;
  endfunction
endpackage

// File: rtl/evs_rst_sync.sv
module evs_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic meta_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q  <= 1'b0;
      rst_n_o <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_n_o <= meta_q;
    end
  end
endmodule

// File: rtl/evs_counter.sv
module evs_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_d  = cnt_o + CNT_W'(1);
    // a clear wins over an increment on the same tick
    if (clr_i) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    cnt_o <= '0;
    else if (cnt_en) cnt_o <= cnt_d;
  end
endmodule

// File: rtl/evs_snap.sv
module evs_snap #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] d_i,
  output logic [CNT_W-1:0] q_o
);
  logic [CNT_W-1:0] q_d;

  always_comb q_d = d_i;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)   q_o <= '0;
    else if (cap_i) q_o <= q_d;
  end
endmodule

// File: rtl/evs_regs.sv
module evs_regs
  import evs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_n_i,
  input  logic                         wr_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WORD_W-1:0]            wdata_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] snap_i,
  output logic [NUM_CH-1:0]            ts_en_o,
  output logic [NUM_CH-1:0]            force_o,
  output logic [WORD_W-1:0]            rdata_o
);
  localparam int HI_W = CNT_W - WORD_W;

  logic              en_we, frc_we;
  logic [NUM_CH-1:0] en_d, frc_d;

  always_comb begin
    en_we  = wr_i && (addr_i == ADDR_W'(EVS_ADDR_TSEN));
    frc_we = wr_i && (addr_i == ADDR_W'(EVS_ADDR_FORCE));
    en_d   = wdata_i[NUM_CH-1:0];
    frc_d  = wdata_i[NUM_CH-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)   ts_en_o <= '0;
    else if (en_we) ts_en_o <= en_d;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    force_o <= '0;
    else if (frc_we) force_o <= frc_d;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(EVS_ADDR_TSEN))  rdata_o[NUM_CH-1:0] = ts_en_o;
    if (addr_i == ADDR_W'(EVS_ADDR_FORCE)) rdata_o[NUM_CH-1:0] = force_o;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(evs_mon_addr(c, 0))) rdata_o = snap_i[c][WORD_W-1:0];
      if (addr_i == ADDR_W'(evs_mon_addr(c, 1))) rdata_o[HI_W-1:0] = snap_i[c][CNT_W-1:WORD_W];
    end
  end
endmodule

// File: rtl/evs_top.sv
module evs_top
  import evs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [NUM_CH-1:0] fired_i,
  input  logic              qual_stb_i,
  input  logic              ts_reset_i,
  input  logic              mon_cap_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o
);
  logic                         rst_sync_n;
  logic [NUM_CH-1:0]            ts_en, force_bits, clr, inc;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt, snap;

  evs_rst_sync u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_sync_n)
  );

  evs_regs #(
    .NUM_CH (NUM_CH), .CNT_W (CNT_W), .WORD_W (WORD_W), .ADDR_W (ADDR_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_n_i (rst_sync_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .snap_i  (snap),
    .ts_en_o (ts_en),
    .force_o (force_bits),
    .rdata_o (reg_rdata_o)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign clr[ch] = (ts_reset_i & ts_en[ch]) | force_bits[ch];
    assign inc[ch] = fired_i[ch] & qual_stb_i;

    evs_counter #(.CNT_W (CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_n_i (rst_sync_n),
      .clr_i   (clr[ch]),
      .inc_i   (inc[ch]),
      .cnt_o   (cnt[ch])
    );

    evs_snap #(.CNT_W (CNT_W)) u_snap (
      .clk_i   (clk_i),
      .rst_n_i (rst_sync_n),
      .cap_i   (mon_cap_i),
      .d_i     (cnt[ch]),
      .q_o     (snap[ch])
    );
  end
endmodule

// File: rtl/evs_checker.sv
module evs_checker #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input logic                         clk_i,
  input logic                         rst_n_i,
  input logic [NUM_CH-1:0]            fired_i,
  input logic                         qual_stb_i,
  input logic                         ts_reset_i,
  input logic                         mon_cap_i,
  input logic [NUM_CH-1:0]            ts_en,
  input logic [NUM_CH-1:0]            force_bits,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] snap
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_count_up_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (fired_i[c] && qual_stb_i && !force_bits[c] && !(ts_reset_i && ts_en[c]))
      |=> cnt[c] == CNT_W'($past(cnt[c]) + CNT_W'(1)));

    assert_count_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!(fired_i[c] && qual_stb_i) && !force_bits[c] && !ts_reset_i)
      |=> $stable(cnt[c]));

    assert_ts_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (ts_reset_i && !ts_en[c] && !force_bits[c] && !(fired_i[c] && qual_stb_i))
      |=> $stable(cnt[c]));

    assert_force_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      force_bits[c] |=> cnt[c] == '0);

    assert_clear_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (ts_reset_i && ts_en[c] && fired_i[c] && qual_stb_i) |=> cnt[c] == '0);

    assert_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      mon_cap_i |=> snap[c] == $past(cnt[c]));

    assert_snap_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !mon_cap_i |=> $stable(snap[c]));
  end
endmodule

bind evs_top evs_checker #(.NUM_CH (NUM_CH), .CNT_W (CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_n_i    (rst_sync_n),
  .fired_i    (fired_i),
  .qual_stb_i (qual_stb_i),
  .ts_reset_i (ts_reset_i),
  .mon_cap_i  (mon_cap_i),
  .ts_en      (ts_en),
  .force_bits (force_bits),
  .cnt        (cnt),
  .snap       (snap)
);

// File: tb/evs_top_tb.sv
`timescale 1ns/100ps
module evs_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  fired;
  logic        qual, tsr, cap, wr;
  logic [3:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;

  logic [3:0]  m_en, m_frc;
  logic [31:0] m_cnt  [4];
  logic [31:0] m_snap [4];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  evs_top u_dut (
    .clk_i (clk), .rst_n_i (rst_n), .fired_i (fired), .qual_stb_i (qual),
    .ts_reset_i (tsr), .mon_cap_i (cap), .reg_wr_i (wr), .reg_addr_i (addr),
    .reg_wdata_i (wdata), .reg_rdata_o (rdata)
  );

  function automatic logic [15:0] exp_read(logic [3:0] a);
    logic [15:0] r = '0;
    if (a == 4'd0) r[3:0] = m_en;
    else if (a == 4'd1) r[3:0] = m_frc;
    else if (a >= 4'd8) r = a[0] ? m_snap[a[2:1]][31:16] : m_snap[a[2:1]][15:0];
    return r;
  endfunction

  // model of one tick edge, all from pre-edge state
  task automatic tick();
    logic [31:0] nc [4];
    for (int c = 0; c < 4; c++) begin
      nc[c] = m_cnt[c];
      if ((tsr && m_en[c]) || m_frc[c]) nc[c] = '0;
      else if (fired[c] && qual) nc[c] = m_cnt[c] + 32'd1;
      if (cap) m_snap[c] = m_cnt[c];
    end
    for (int c = 0; c < 4; c++) m_cnt[c] = nc[c];
    if (wr && addr == 4'd0) m_en  = wdata[3:0];
    if (wr && addr == 4'd1) m_frc = wdata[3:0];
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    fired = '0; qual = 0; tsr = 0; cap = 0; wr = 0; wdata = '0;
  endtask

  task automatic check(string tag, logic [3:0] a);
    logic [15:0] e;
    addr = a;
    #0.2;
    e = exp_read(a);
    checks++;
    if (rdata !== e) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rdata, e);
    end
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < 16; a++) check(tag, 4'(a));
  endtask

  task automatic write(logic [3:0] a, logic [15:0] d);
    idle(); wr = 1; addr = a; wdata = d;
    tick();
    idle();
  endtask

  task automatic capture();
    idle(); cap = 1; tick(); idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(); addr = '0; rst_n = 0;
    m_en = '0; m_frc = '0;
    for (int c = 0; c < 4; c++) begin m_cnt[c] = '0; m_snap[c] = '0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) tick();
    sweep("R1");

    // R2: only fired & strobe counts, per channel mask
    fired = 4'b0101; qual = 1; tick();
    fired = 4'b1111; qual = 0; repeat (3) tick();
    fired = 4'b0000; qual = 1; tick();
    fired = 4'b0101; qual = 1; repeat (2) tick();
    capture();
    check("R2", 4'd8); check("R2", 4'd10); check("R2", 4'd12); check("R2", 4'd14);
    check("R7", 4'd9);

    // R6: snapshot holds while counters move, then refreshes on capture
    fired = 4'b1111; qual = 1; repeat (2) tick(); idle();
    check("R6", 4'd8); check("R6", 4'd10);
    capture();
    check("R6", 4'd8); check("R6", 4'd14);

    // R8: register readback and unmapped address
    write(4'd0, 16'hFFFF);
    check("R8", 4'd0); check("R8", 4'd5);
    write(4'd0, 16'h0001);

    // R3 / R5: timing reset with increment on the same tick
    fired = 4'b1111; qual = 1; tsr = 1; tick(); idle();
    capture();
    check("R5", 4'd8); check("R3", 4'd10); check("R3", 4'd14);

    // R4: force clear regardless of enable
    write(4'd0, 16'h0000);
    write(4'd1, 16'h0004);
    check("R8", 4'd1);
    fired = 4'b1111; qual = 1; tsr = 1; repeat (3) tick(); idle();
    capture();
    check("R4", 4'd12); check("R4", 4'd8);
    write(4'd1, 16'h0000);

    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      fired = 4'($urandom);
      qual  = ($urandom % 4) == 0;
      tsr   = ($urandom % 20) == 0;
      cap   = ($urandom % 5) == 0;
      wr    = ($urandom % 25) == 0;
      addr  = 4'($urandom % 2);
      wdata = 16'($urandom);
      if (addr == 4'd1 && wr) wdata = wdata & 16'($urandom);
      tick();
      check("R7", 4'($urandom));
      if (i % 500 == 0) sweep("R6");
    end
    idle(); tick(); capture();
    sweep("R7");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule